// File: doc/BRIEF.md
# Pulse-Width Modulator with Full-Scale Zero Code

This block produces a single pulse-width-modulated output from a 4-bit duty code. A free-running binary phase counter divides time into periods of 16 clocks. Within each period the output is high for the first `duty_code` clocks and low for the rest. The code zero does not mean "off": it means the output stays high for the whole period. A duty of 0 percent therefore cannot be requested, and the range runs from 1/16 up to 16/16.

The duty code is captured only at the boundary between periods, so every period carries one complete, undistorted pulse. Changes to the input during a period are held off until the next boundary. The output comes straight from a flip-flop, so it is free of glitches. A synchronous reset restarts the phase counter and forces the output low. While reset is held, the duty register follows the input, so the first period after release already uses the code present at release.

Top module: `duty_pwm`

## Requirements
- R1: The period is exactly 16 clocks. The phase counter counts 0 to 15 and returns to 0, and the output pattern repeats every 16 clocks while the code is unchanged.
- R2: For a nonzero code `c`, the output is high for exactly `c` of the 16 clocks in each period.
- R3: For code 0000, the output is high for all 16 clocks of each period.
- R4: The high clocks are the first ones of the period. With the first output clock after a period boundary counted as index 0, the output is high at index `i` exactly when the code is 0 or `i` < `c`.
- R5: The code is taken into the duty register only on the clock edge at which the phase counter wraps from 15 to 0. A code change during a period has no effect on that period's output, and the code present at the wrap edge governs the whole next period.
- R6: While `rst` is high at a clock edge, the output goes low, the phase counter goes to 0 and the duty register loads `duty_code`. The first clock edge after release begins a new period that uses that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state changes on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| duty_code | input | CNT_W (4) | Duty code. 0 means full scale; otherwise it is the number of high clocks per period. |
| pwm_out | output | 1 | Registered PWM output. |

## Verification
The hardest case to reach from the ports is a code change that lands inside a period, because the block must ignore it until the boundary. The ports give no view of where the boundary falls. The bench therefore counts clock edges from reset release to track the phase itself. Every other period, it drives a wrong code in the middle of the period and only then drives the real next code, just before the wrap edge. A reset is also asserted partway through a period, to confirm that the phase restarts and that the code sampled during reset applies to the first new period.

// File: rtl/duty_pwm_pkg.sv
package duty_pwm_pkg;

  // Level of the output for a given phase within the period and a duty code.
  // Code zero selects full scale.
  function automatic logic level_at(input int unsigned phase,
                                    input int unsigned code);
    return (code == 0) || (phase < code);
  endfunction

  // Modulo increment used by the phase counter.
  function automatic int unsigned wrap_inc(input int unsigned value,
                                           input int unsigned modulus);
    return (value + 1 == modulus) ? 0 : value + 1;
  endfunction

endpackage

// File: rtl/duty_pwm_phase.sv
module duty_pwm_phase #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] phase,
  output logic         last
);
  import duty_pwm_pkg::*;

  localparam int unsigned MODULUS = 1 << W;
  localparam logic [W-1:0] LAST_PHASE = W'(MODULUS - 1);

  assign last = (phase == LAST_PHASE);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= W'(wrap_inc(32'(phase), MODULUS));
  end
endmodule

// File: rtl/duty_pwm_latch.sv
module duty_pwm_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] duty
);
  // Loads during reset and at each period boundary; holds otherwise.
  always_ff @(posedge clk) begin
    if (rst || take) duty <= code_in;
  end
endmodule

// File: rtl/duty_pwm_out.sv
module duty_pwm_out #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] phase,
  input  logic [W-1:0] duty,
  output logic         level
);
  import duty_pwm_pkg::*;

  logic level_d;
  assign level_d = level_at(32'(phase), 32'(duty));

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b0;
    else     level <= level_d;
  end
endmodule

// File: rtl/duty_pwm.sv
module duty_pwm #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] duty_code,
  output logic             pwm_out
);
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] duty_q;
  logic             period_end;

  duty_pwm_phase #(.W(CNT_W)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_q),
    .last  (period_end)
  );

  duty_pwm_latch #(.W(CNT_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .take    (period_end),
    .code_in (duty_code),
    .duty    (duty_q)
  );

  duty_pwm_out #(.W(CNT_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .phase (phase_q),
    .duty  (duty_q),
    .level (pwm_out)
  );
endmodule

// File: rtl/duty_pwm_chk.sv
module duty_pwm_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] phase,
  input logic [W-1:0] duty,
  input logic [W-1:0] code,
  input logic         wrap,
  input logic         pwm
);
  localparam logic [W-1:0] TOP = '1;

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == TOP) |=> (phase == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (phase != TOP) |=> (phase == $past(phase) + 1'b1));

  assert_low_tail_R2: assert property (@(posedge clk) disable iff (rst)
    ((duty != '0) && (phase >= duty)) |=> !pwm);

  assert_full_scale_R3: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |=> pwm);

  assert_high_head_R4: assert property (@(posedge clk) disable iff (rst)
    (phase < duty) |=> pwm);

  assert_hold_midperiod_R5: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(duty));

  assert_take_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (duty == $past(code)));

  assert_reset_state_R6: assert property (@(posedge clk)
    rst |=> (!pwm && (phase == '0) && (duty == $past(code))));
endmodule

bind duty_pwm duty_pwm_chk #(.W(CNT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .phase (phase_q),
  .duty  (duty_q),
  .code  (duty_code),
  .wrap  (period_end),
  .pwm   (pwm_out)
);

// File: tb/duty_pwm_tb.sv
module duty_pwm_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] code = 4'd3;
  logic       pwm;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  duty_pwm #(.CNT_W(4)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .duty_code (code),
    .pwm_out   (pwm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Observes one full period that must use exp_code. Drives next_code just
  // before the wrap edge; with disturb set, a wrong code is driven mid-period.
  task automatic window(input int exp_code, input int next_code, input bit disturb);
    int highs = 0;
    int first_bad = -1;
    int exp_highs;
    for (int i = 0; i < 16; i++) begin
      logic want;
      step();
      want = (exp_code == 0) || (i < exp_code);
      if (pwm) highs++;
      if ((pwm !== want) && (first_bad < 0)) first_bad = i;
      if (disturb && (i == 5)) code = 4'(exp_code + 7);
      if (i == 14) code = 4'(next_code);
    end
    exp_highs = (exp_code == 0) ? 16 : exp_code;
    if (exp_code == 0) check(highs == exp_highs, "R3 full-scale high count", highs, exp_highs);
    else               check(highs == exp_highs, "R2 high count", highs, exp_highs);
    check(first_bad < 0, "R1 R4 period shape, first bad index", first_bad, -1);
    if (disturb) check(first_bad < 0, "R5 mid-period code change ignored", first_bad, -1);
  endtask

  initial begin
    int cur;
    for (int k = 0; k < 3; k++) begin
      step();
      check(pwm == 1'b0, "R6 output low in reset", int'(pwm), 0);
    end
    rst = 1'b0;
    cur = 3;
    for (int n = 0; n < 16; n++) begin
      window(cur, n, n[0]);
      cur = n;
    end
    window(15, 15, 1'b0);
    window(15, 0, 1'b1);
    window(0, 0, 1'b0);
    window(0, 1, 1'b1);
    window(1, 6, 1'b0);
    // Reset in the middle of a period.
    for (int k = 0; k < 6; k++) step();
    rst  = 1'b1;
    code = 4'd9;
    step();
    check(pwm == 1'b0, "R6 output low after mid-period reset", int'(pwm), 0);
    step();
    rst = 1'b0;
    window(9, 1, 1'b0);
    window(1, 1, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule